// File: doc/BRIEF.md
# Configurable UART Framer with Line Status

This block is the serial core of an asynchronous port. It serialises one character at a time from a transmit holding register and rebuilds characters arriving on the serial input into a receive holding register. A 7-bit line-control word sets the character shape for both directions:

- the number of data bits;
- one or two stop bits;
- whether a parity bit is present and how its value is chosen;
- whether the transmitter holds the line in a break.

The bit clock comes from a 16-bit divisor of the peripheral clock. The divisor is loaded one byte at a time. Every bit lasts sixteen ticks of the divided clock.

The receiver qualifies a start bit at its midpoint. It then samples each following bit at its centre and checks the result. The outcome goes into an 8-bit line-status word with these parts:

- a data-ready flag;
- sticky overrun, parity, framing and break flags;
- a summary error flag;
- two transmitter occupancy flags.

A one-cycle status-clear strobe drops the sticky flags. A one-cycle read strobe consumes the received character.

Top module: `uart_line_framer`

## Requirements
- R1: After reset, lineStatus reads 0x60 (only bits 6 and 5 set) and serialOut is high.
- R2: A frame on serialOut is made of the following, in order: a low start bit; the data bits, least significant first, numbering 5 + lineCtrl[1:0]; an optional parity bit; then one high stop bit, or two when lineCtrl[2] is 1. The line idles high.
- R3: lineCtrl[3] adds a parity bit in both directions. lineCtrl[5:4] picks its value: 0 makes the count of ones over data plus parity odd, 1 makes it even, 2 sends a constant 1 and 3 sends a constant 0.
- R4: A one-cycle pulse on divLoWr or divHiWr loads divByte into the low or high byte of the divisor. Each serial bit lasts 16 × divisor clock cycles, and a divisor of zero behaves as one. The reset divisor is 1.
- R5: When a frame ends, rxData holds its data bits right-aligned with the unused upper bits zero, and lineStatus[0] (data ready) becomes 1. A pulse on rxRd clears it.
- R6: A character completing while lineStatus[0] is still 1 sets lineStatus[1] (overrun), and the new character replaces the old one.
- R7: A received parity bit that disagrees with the R3 rule sets lineStatus[2].
- R8: A low level sampled at the centre of the first stop bit sets lineStatus[3] (framing).
- R9: A frame whose data, parity (if present) and first stop bit are all low sets lineStatus[4] (break). The receiver then waits for the line to return high before it looks for a new start bit.
- R10: A statusRd pulse clears lineStatus[4:1] and leaves lineStatus[0] as it was. These flags otherwise stay set. lineStatus[7] is 1 whenever any of lineStatus[4:1] is 1.
- R11: While lineCtrl[6] is 1, serialOut is held low.
- R12: lineStatus[5] is 1 when the transmit holding register is free. lineStatus[6] is 1 when the transmit holding register and the shift register are both empty. A txWr pulse fills the holding register, which moves to the shifter on the next clock if the transmitter is idle.
- R13: A low pulse on serialIn shorter than half a bit time starts no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lineCtrl | input | 7 | Character format: [1:0] length, [2] two stops, [3] parity on, [5:4] parity rule, [6] break |
| divLoWr | input | 1 | Load divByte into the divisor low byte |
| divHiWr | input | 1 | Load divByte into the divisor high byte |
| divByte | input | 8 | Divisor byte value |
| txWr | input | 1 | Write txData into the transmit holding register |
| txData | input | 8 | Character to send |
| rxRd | input | 1 | Consume the received character |
| statusRd | input | 1 | Clear the sticky error flags |
| serialIn | input | 1 | Serial receive line |
| serialOut | output | 1 | Serial transmit line |
| rxData | output | 8 | Last received character |
| lineStatus | output | 8 | {anyErr, txEmpty, holdEmpty, break, framing, parity, overrun, dataReady} |

## Verification
Transmitted bits are due at fixed multiples of 16 × divisor cycles after the first low level seen on serialOut. The bench finds that edge, moves half a bit into the start bit and samples every later bit one full bit period apart. This keeps each sample at the centre of its bit despite up to one tick of phase uncertainty at load.

Received results are due at the centre of the first stop bit. The two-flop input synchroniser and the start-detect tick add at most a few cycles to that point. The bench therefore reads rxData and lineStatus a few cycles after it finishes driving the last stop bit.

The holding-register flags are sampled exactly one and two clock edges after a write. The divisor is checked by counting clocks between two data-bit transitions of a 0x55 character.

// File: rtl/uart_framer_pkg.sv
package uart_framer_pkg;

  localparam int DATA_W = 8;
  localparam int LC_W   = 7;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_STOP   = 3'd4
  } txPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxCapture;
    logic rxParCap;
    logic rxDone;
  } frameStrobes_t;

  typedef struct packed {
    logic       breakCtl;
    logic [1:0] parMode;
    logic       parEn;
    logic       twoStop;
    logic [1:0] lenSel;
  } lineCfg_t;

  // mask of the live data bits for a length code (0 -> 5 bits .. 3 -> 8 bits)
  function automatic logic [DATA_W-1:0] lenMask(input logic [1:0] lenSel);
    return {DATA_W{1'b1}} >> (2'd3 - lenSel);
  endfunction

  // parity bit for already-masked data under a parity rule
  function automatic logic parityOf(input logic [DATA_W-1:0] d, input logic [1:0] mode);
    case (mode)
      2'd0:    parityOf = ~(^d);
      2'd1:    parityOf = ^d;
      2'd2:    parityOf = 1'b1;
      default: parityOf = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16,
  parameter int BYTE_W = DIV_W / 2,
  parameter logic [DIV_W-1:0] RESET_DIV = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              divLoWr,
  input  logic              divHiWr,
  input  logic [BYTE_W-1:0] divByte,
  output logic              tick
);

  logic [BYTE_W-1:0] divLo, divHi;
  logic [DIV_W-1:0]  divisor, limit, cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divLo <= RESET_DIV[BYTE_W-1:0];
      divHi <= RESET_DIV[DIV_W-1:BYTE_W];
    end else begin
      if (divLoWr) divLo <= divByte;
      if (divHiWr) divHi <= divByte;
    end
  end

  assign divisor = {divHi, divLo};
  assign limit   = (divisor == '0) ? '0 : divisor - DIV_W'(1);
  assign tick    = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + DIV_W'(1);
  end

endmodule

// File: rtl/uart_framer_ctrl.sv
module uart_framer_ctrl
  import uart_framer_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [1:0]    lenSel,
  input  logic          parEn,
  input  logic          twoStop,
  input  logic          txHoldFull,
  input  logic          rxLine,
  output frameStrobes_t stb,
  output txPhase_e      txPhase,
  output logic          txIdle
);

  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OVS / 2 - 1);

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP, RX_HOLDLOW
  } rxState_e;

  logic [2:0] lastDataIdx;
  assign lastDataIdx = {1'b1, lenSel};

  // ---------------- transmitter sequencing ----------------
  txPhase_e         txSt;
  logic [CNT_W-1:0] txCnt;
  logic [2:0]       txBit;
  logic             txStop2;
  logic             txBitEnd;

  assign txBitEnd = tick && (txCnt == LAST_TICK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txSt    <= PH_IDLE;
      txCnt   <= '0;
      txBit   <= '0;
      txStop2 <= 1'b0;
    end else begin
      if (txSt != PH_IDLE && tick)
        txCnt <= txBitEnd ? '0 : txCnt + 1'b1;
      case (txSt)
        PH_IDLE: if (txHoldFull) begin
          txSt  <= PH_START;
          txCnt <= '0;
        end
        PH_START: if (txBitEnd) begin
          txSt    <= PH_DATA;
          txBit   <= '0;
          txStop2 <= 1'b0;
        end
        PH_DATA: if (txBitEnd) begin
          if (txBit == lastDataIdx) txSt <= parEn ? PH_PARITY : PH_STOP;
          else                      txBit <= txBit + 1'b1;
        end
        PH_PARITY: if (txBitEnd) txSt <= PH_STOP;
        PH_STOP: if (txBitEnd) begin
          if (twoStop && !txStop2) txStop2 <= 1'b1;
          else                     txSt    <= PH_IDLE;
        end
        default: txSt <= PH_IDLE;
      endcase
    end
  end

  // ---------------- receiver sequencing ----------------
  rxState_e         rxSt;
  logic [CNT_W-1:0] rxCnt;
  logic [2:0]       rxBit;
  logic             rxBitEnd;

  assign rxBitEnd = tick && (rxCnt == LAST_TICK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxSt  <= RX_IDLE;
      rxCnt <= '0;
      rxBit <= '0;
    end else begin
      case (rxSt)
        RX_IDLE: if (tick && !rxLine) begin
          rxSt  <= RX_START;
          rxCnt <= '0;
        end
        RX_START: if (tick) begin
          if (rxCnt == MID_TICK) begin
            rxCnt <= '0;
            rxBit <= '0;
            rxSt  <= rxLine ? RX_IDLE : RX_DATA;
          end else rxCnt <= rxCnt + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (rxBitEnd) begin
            rxCnt <= '0;
            if (rxBit == lastDataIdx) rxSt <= parEn ? RX_PARITY : RX_STOP;
            else                      rxBit <= rxBit + 1'b1;
          end else rxCnt <= rxCnt + 1'b1;
        end
        RX_PARITY: if (tick) begin
          if (rxBitEnd) begin
            rxCnt <= '0;
            rxSt  <= RX_STOP;
          end else rxCnt <= rxCnt + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (rxBitEnd) begin
            rxCnt <= '0;
            rxSt  <= rxLine ? RX_IDLE : RX_HOLDLOW;
          end else rxCnt <= rxCnt + 1'b1;
        end
        RX_HOLDLOW: if (rxLine) rxSt <= RX_IDLE;
        default: rxSt <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.txLoad    = (txSt == PH_IDLE) && txHoldFull;
    stb.txShift   = (txSt == PH_DATA) && txBitEnd;
    stb.rxCapture = (rxSt == RX_DATA) && rxBitEnd;
    stb.rxParCap  = (rxSt == RX_PARITY) && rxBitEnd;
    stb.rxDone    = (rxSt == RX_STOP) && rxBitEnd;
  end

  assign txPhase = txSt;
  assign txIdle  = (txSt == PH_IDLE);

endmodule

// File: rtl/uart_framer_dp.sv
module uart_framer_dp
  import uart_framer_pkg::*;
#(
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  frameStrobes_t     stb,
  input  txPhase_e          txPhase,
  input  logic              txIdle,
  input  logic [1:0]        lenSel,
  input  logic              parEn,
  input  logic [1:0]        parMode,
  input  logic              breakCtl,
  input  logic              txWr,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRd,
  input  logic              statusRd,
  input  logic              serialIn,
  output logic              serialOut,
  output logic [DATA_W-1:0] rxData,
  output logic [7:0]        lineStatus,
  output logic              txHoldFull,
  output logic              rxLine
);

  // ---------------- input synchroniser ----------------
  logic [SYNC_LEN-1:0] syncQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '1;
    else        syncQ <= {syncQ[SYNC_LEN-2:0], serialIn};
  end
  assign rxLine = syncQ[SYNC_LEN-1];

  // ---------------- transmit path ----------------
  logic [DATA_W-1:0] txHold, txShiftReg, loadWord;
  logic              holdFull, txParReg;

  assign loadWord = txHold & lenMask(lenSel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txHold     <= '0;
      holdFull   <= 1'b0;
      txShiftReg <= '0;
      txParReg   <= 1'b0;
    end else begin
      if (txWr) begin
        txHold   <= txData;
        holdFull <= 1'b1;
      end else if (stb.txLoad) begin
        holdFull <= 1'b0;
      end
      if (stb.txLoad) begin
        txShiftReg <= loadWord;
        txParReg   <= parityOf(loadWord, parMode);
      end else if (stb.txShift) begin
        txShiftReg <= {1'b0, txShiftReg[DATA_W-1:1]};
      end
    end
  end

  always_comb begin
    if (breakCtl) serialOut = 1'b0;
    else begin
      case (txPhase)
        PH_START:  serialOut = 1'b0;
        PH_DATA:   serialOut = txShiftReg[0];
        PH_PARITY: serialOut = txParReg;
        default:   serialOut = 1'b1;
      endcase
    end
  end

  assign txHoldFull = holdFull;

  // ---------------- receive path ----------------
  logic [DATA_W-1:0] rxShiftReg, rxWord, rxHold;
  logic              rxParReg;
  logic              dataReady, overrunF, parityF, frameF, breakF;
  logic              evParity, evFrame, evBreak, evOverrun;

  assign rxWord    = (rxShiftReg >> (2'd3 - lenSel)) & lenMask(lenSel);
  assign evParity  = parEn && (rxParReg != parityOf(rxWord, parMode));
  assign evFrame   = !rxLine;
  assign evBreak   = (rxWord == '0) && !(parEn && rxParReg) && !rxLine;
  assign evOverrun = dataReady && !rxRd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShiftReg <= '0;
      rxParReg   <= 1'b0;
      rxHold     <= '0;
      dataReady  <= 1'b0;
    end else begin
      if (stb.rxCapture) rxShiftReg <= {rxLine, rxShiftReg[DATA_W-1:1]};
      if (stb.rxParCap)  rxParReg   <= rxLine;
      if (stb.rxDone) begin
        rxHold    <= rxWord;
        dataReady <= 1'b1;
      end else if (rxRd) begin
        dataReady <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrunF <= 1'b0;
      parityF  <= 1'b0;
      frameF   <= 1'b0;
      breakF   <= 1'b0;
    end else begin
      if (stb.rxDone && evOverrun) overrunF <= 1'b1;
      else if (statusRd)           overrunF <= 1'b0;
      if (stb.rxDone && evParity)  parityF <= 1'b1;
      else if (statusRd)           parityF <= 1'b0;
      if (stb.rxDone && evFrame)   frameF <= 1'b1;
      else if (statusRd)           frameF <= 1'b0;
      if (stb.rxDone && evBreak)   breakF <= 1'b1;
      else if (statusRd)           breakF <= 1'b0;
    end
  end

  assign rxData     = rxHold;
  assign lineStatus = {(overrunF | parityF | frameF | breakF),
                       (!holdFull && txIdle), !holdFull,
                       breakF, frameF, parityF, overrunF, dataReady};

endmodule

// File: rtl/uart_line_framer.sv
module uart_line_framer
  import uart_framer_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int OVS      = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LC_W-1:0]   lineCtrl,
  input  logic              divLoWr,
  input  logic              divHiWr,
  input  logic [DIV_W/2-1:0] divByte,
  input  logic              txWr,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRd,
  input  logic              statusRd,
  input  logic              serialIn,
  output logic              serialOut,
  output logic [DATA_W-1:0] rxData,
  output logic [7:0]        lineStatus
);

  lineCfg_t      cfg;
  frameStrobes_t stb;
  txPhase_e      txPhase;
  logic          tick, txIdle, txHoldFull, rxLine;

  assign cfg = lineCfg_t'(lineCtrl);

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n),
    .divLoWr(divLoWr), .divHiWr(divHiWr), .divByte(divByte),
    .tick(tick)
  );

  uart_framer_ctrl #(.OVS(OVS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .lenSel(cfg.lenSel), .parEn(cfg.parEn), .twoStop(cfg.twoStop),
    .txHoldFull(txHoldFull), .rxLine(rxLine),
    .stb(stb), .txPhase(txPhase), .txIdle(txIdle)
  );

  uart_framer_dp #(.SYNC_LEN(SYNC_LEN)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .txPhase(txPhase), .txIdle(txIdle),
    .lenSel(cfg.lenSel), .parEn(cfg.parEn), .parMode(cfg.parMode),
    .breakCtl(cfg.breakCtl),
    .txWr(txWr), .txData(txData), .rxRd(rxRd), .statusRd(statusRd),
    .serialIn(serialIn), .serialOut(serialOut), .rxData(rxData),
    .lineStatus(lineStatus), .txHoldFull(txHoldFull), .rxLine(rxLine)
  );

endmodule

// File: rtl/uart_framer_checker.sv
module uart_framer_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       breakCtl,
  input logic       txWr,
  input logic       rxRd,
  input logic       statusRd,
  input logic       serialOut,
  input logic [6:0] lineStatus
);

  AST_BREAK_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    breakCtl |-> !serialOut); // R11

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (lineStatus[6] && !breakCtl) |-> serialOut); // R2

  AST_EMPTY_IMPLIES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    lineStatus[6] |-> lineStatus[5]); // R12

  AST_WRITE_FILLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    txWr |=> !lineStatus[5]); // R12

  AST_READY_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (lineStatus[0] && !rxRd) |=> lineStatus[0]); // R5

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lineStatus[1] && !statusRd) |=> lineStatus[1]); // R6

  AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lineStatus[2] && !statusRd) |=> lineStatus[2]); // R7

  AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lineStatus[3] && !statusRd) |=> lineStatus[3]); // R8

  AST_BREAK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lineStatus[4] && !statusRd) |=> lineStatus[4]); // R9

endmodule

bind uart_line_framer uart_framer_checker u_chk (
  .clk(clk), .rst_n(rst_n), .breakCtl(lineCtrl[6]), .txWr(txWr),
  .rxRd(rxRd), .statusRd(statusRd), .serialOut(serialOut),
  .lineStatus(lineStatus[6:0])
);

// File: tb/uart_line_framer_test.sv
module uart_line_framer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] lineCtrl = 7'h03;
  logic       divLoWr = 1'b0, divHiWr = 1'b0;
  logic [7:0] divByte = '0;
  logic       txWr = 1'b0;
  logic [7:0] txData = '0;
  logic       rxRd = 1'b0, statusRd = 1'b0;
  logic       serialIn = 1'b1;
  logic       serialOut;
  logic [7:0] rxData;
  logic [7:0] lineStatus;

  int  checks = 0;
  int  fails = 0;
  bit  finished = 1'b0;
  int  divNow = 1;

  always #5 clk = ~clk;

  uart_line_framer uut (
    .clk(clk), .rst_n(rst_n), .lineCtrl(lineCtrl),
    .divLoWr(divLoWr), .divHiWr(divHiWr), .divByte(divByte),
    .txWr(txWr), .txData(txData), .rxRd(rxRd), .statusRd(statusRd),
    .serialIn(serialIn), .serialOut(serialOut), .rxData(rxData),
    .lineStatus(lineStatus)
  );

  function automatic int bitClks();
    return 16 * divNow;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setDiv(input int lo, input int hi);
    @(negedge clk); divByte = 8'(lo); divLoWr = 1'b1;
    @(negedge clk); divLoWr = 1'b0; divByte = 8'(hi); divHiWr = 1'b1;
    @(negedge clk); divHiWr = 1'b0;
    divNow = (hi * 256 + lo == 0) ? 1 : hi * 256 + lo;
  endtask

  function automatic logic expParity(input logic [6:0] lc, input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < 5 + int'(lc[1:0]); i++) ones += int'(d[i]);
    case (lc[5:4])
      2'd0:    return (ones % 2 == 0);
      2'd1:    return (ones % 2 == 1);
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic buildFrame(input logic [6:0] lc, input logic [7:0] d,
                            input bit flipPar, input bit stopVal,
                            output logic [11:0] bits, output int n);
    int len = 5 + int'(lc[1:0]);
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < len; i++) bits[1 + i] = d[i];
    n = 1 + len;
    if (lc[3]) begin
      bits[n] = expParity(lc, d) ^ flipPar;
      n++;
    end
    bits[n] = stopVal;
    n++;
    if (lc[2]) n++;
  endtask

  task automatic sendBits(input logic [11:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      serialIn = bits[i];
      waitClk(bitClks());
    end
    serialIn = 1'b1;
  endtask

  task automatic pulseRxRd();
    rxRd = 1'b1; @(negedge clk); rxRd = 1'b0; @(negedge clk);
  endtask

  task automatic pulseStatusRd();
    statusRd = 1'b1; @(negedge clk); statusRd = 1'b0; @(negedge clk);
  endtask

  task automatic waitTxEmpty();
    int guard = 0;
    while (!lineStatus[6] && guard < 200000) begin @(negedge clk); guard++; end
  endtask

  task automatic waitLineLow();
    int guard = 0;
    while (serialOut && guard < 200000) begin @(negedge clk); guard++; end
  endtask

  // R2 R3: transmitted frame shape under one format
  task automatic txCheck(input logic [6:0] lc, input logic [7:0] d);
    logic [11:0] bits, got;
    int n;
    lineCtrl = lc;
    buildFrame(lc, d, 1'b0, 1'b1, bits, n);
    @(negedge clk); txWr = 1'b1; txData = d;
    @(negedge clk); txWr = 1'b0;
    waitLineLow();
    waitClk(bitClks() / 2);
    got = '1;
    for (int i = 0; i < n; i++) begin
      got[i] = serialOut;
      if (i < n - 1) waitClk(bitClks());
    end
    check(got == bits, "R2 R3", $sformatf("tx frame lc=%0h", lc), int'(got), int'(bits));
    waitTxEmpty();
  endtask

  // R5 R3: received frame under one format
  task automatic rxCheck(input logic [6:0] lc, input logic [7:0] d);
    logic [11:0] bits;
    int n;
    logic [7:0] expData;
    lineCtrl = lc;
    expData = d & (8'hFF >> (3 - int'(lc[1:0])));
    buildFrame(lc, d, 1'b0, 1'b1, bits, n);
    sendBits(bits, n);
    waitClk(4);
    check(rxData == expData, "R5", $sformatf("rx data lc=%0h", lc), int'(rxData), int'(expData));
    check(lineStatus == 8'h61, "R5 R3", $sformatf("rx status lc=%0h", lc), int'(lineStatus), 8'h61);
    pulseRxRd();
    check(lineStatus[0] == 1'b0, "R5", "ready after read", int'(lineStatus[0]), 0);
  endtask

  task automatic measureBit(input int lo, input int hi, input int expClks);
    int cnt = 0;
    int guard = 0;
    setDiv(lo, hi);
    lineCtrl = 7'h03;
    @(negedge clk); txWr = 1'b1; txData = 8'h55;
    @(negedge clk); txWr = 1'b0;
    waitLineLow();
    while (!serialOut && guard < 200000) begin @(negedge clk); guard++; end
    while (serialOut && cnt < 200000) begin @(negedge clk); cnt++; end
    check(cnt == expClks, "R4", $sformatf("bit period div=%0d", hi * 256 + lo), cnt, expClks);
    waitTxEmpty();
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stimulus
    logic [11:0] bits;
    int n;
    int idx;

    waitClk(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(lineStatus == 8'h60, "R1", "reset status", int'(lineStatus), 8'h60);
    check(serialOut == 1'b1, "R1", "reset line", int'(serialOut), 1);

    setDiv(3, 0);

    // sweep every format: length, stop count, parity off / four rules
    idx = 0;
    for (int len = 0; len < 4; len++) begin
      for (int stp = 0; stp < 2; stp++) begin
        for (int pm = 0; pm < 5; pm++) begin
          logic [6:0] lc;
          logic [7:0] d;
          lc = {1'b0, (pm == 4) ? 2'd0 : 2'(pm), (pm != 4), 1'(stp), 2'(len)};
          d  = 8'(idx * 53 + 8'hA5);
          txCheck(lc, d);
          rxCheck(lc, d);
          idx++;
        end
      end
    end

    // R6: overrun
    lineCtrl = 7'h03;
    buildFrame(7'h03, 8'h11, 1'b0, 1'b1, bits, n); sendBits(bits, n);
    buildFrame(7'h03, 8'h22, 1'b0, 1'b1, bits, n); sendBits(bits, n);
    waitClk(4);
    check(rxData == 8'h22, "R6", "overrun keeps newest", int'(rxData), 8'h22);
    check(lineStatus == 8'hE3, "R6", "overrun status", int'(lineStatus), 8'hE3);
    pulseStatusRd();
    check(lineStatus == 8'h61, "R10", "clear keeps ready", int'(lineStatus), 8'h61);
    pulseRxRd();

    // R7: parity error, even rule, 8 bits
    lineCtrl = 7'h1B;
    buildFrame(7'h1B, 8'h3C, 1'b1, 1'b1, bits, n); sendBits(bits, n);
    waitClk(4);
    check(lineStatus == 8'hE5, "R7", "parity error status", int'(lineStatus), 8'hE5);
    check(rxData == 8'h3C, "R7", "parity error data", int'(rxData), 8'h3C);
    pulseStatusRd();
    check(lineStatus == 8'h61, "R10", "parity flag cleared", int'(lineStatus), 8'h61);
    pulseRxRd();

    // R8: framing error
    lineCtrl = 7'h03;
    buildFrame(7'h03, 8'h5A, 1'b0, 1'b0, bits, n); sendBits(bits, n);
    waitClk(4);
    check(lineStatus == 8'hE9, "R8", "framing status", int'(lineStatus), 8'hE9);
    check(rxData == 8'h5A, "R8", "framing data", int'(rxData), 8'h5A);
    pulseStatusRd();
    pulseRxRd();

    // R9: break held beyond one frame
    buildFrame(7'h03, 8'h00, 1'b0, 1'b0, bits, n);
    for (int i = 0; i < n; i++) begin
      serialIn = bits[i];
      waitClk(bitClks());
    end
    waitClk(2 * bitClks());
    serialIn = 1'b1;
    waitClk(4);
    check(lineStatus == 8'hF9, "R9", "break status", int'(lineStatus), 8'hF9);
    pulseStatusRd();
    pulseRxRd();
    waitClk(2 * bitClks());
    check(lineStatus == 8'h60, "R9", "no char after break", int'(lineStatus), 8'h60);

    // R13: short low pulse
    serialIn = 1'b0;
    waitClk(4 * divNow);
    serialIn = 1'b1;
    waitClk(3 * bitClks());
    check(lineStatus == 8'h60, "R13", "glitch rejected", int'(lineStatus), 8'h60);

    // R11: break generation
    lineCtrl = 7'h43;
    waitClk(2);
    check(serialOut == 1'b0, "R11", "break drives low", int'(serialOut), 0);
    lineCtrl = 7'h03;
    waitClk(1);
    check(serialOut == 1'b1, "R11", "break released", int'(serialOut), 1);

    // R12: holding and shifter occupancy
    @(negedge clk); txWr = 1'b1; txData = 8'h3C;
    @(negedge clk); txWr = 1'b0;
    check(lineStatus[6:5] == 2'b00, "R12", "after write", int'(lineStatus[6:5]), 0);
    @(negedge clk);
    check(lineStatus[6:5] == 2'b01, "R12", "after load", int'(lineStatus[6:5]), 1);
    txWr = 1'b1; txData = 8'hC3;
    @(negedge clk); txWr = 1'b0;
    waitClk(bitClks());
    check(lineStatus[6:5] == 2'b00, "R12", "second char waiting", int'(lineStatus[6:5]), 0);
    waitTxEmpty();
    check(lineStatus[6:5] == 2'b11, "R12", "all sent", int'(lineStatus[6:5]), 3);

    // R4: divisor bytes and zero divisor
    measureBit(5, 0, 80);
    measureBit(0, 1, 4096);
    measureBit(0, 0, 16);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule